// File: doc/BRIEF.md
# Branch Condition Evaluator with Flag Register

This block keeps four arithmetic condition flags, which it captures from the ALU whenever a flag-producing operation completes. A branch instruction supplies a 4-bit condition selector. The block tests the stored flags against the selected condition, decides whether the branch is taken and forms the next program counter.

The caller provides a program counter that has already been incremented past the branch. When the branch is taken, the block adds a signed displacement to that value. The displacement counts instruction words, and a parameter gives the scaling to bytes. When the branch is not taken, the incremented counter passes through unchanged.

The sixteen selector codes split into two halves. Codes 8 to 15 are the exact logical inverses of codes 0 to 7. This lets a parameter choose between two implementations: one folds the inversion into a single exclusive-or on the top selector bit, the other uses a flat sixteen-way decode.

Top module: `branch_cond_unit`

## Requirements
- R1: While reset is asserted and after it is released, the stored flags are all zero until the first enabled write. So with no write yet, selector 1 reads not taken and selectors 9 and 14 read taken.
- R2: The stored flags take the value of `flags_in` at a rising clock edge only when `flags_we` is 1. With `flags_we` at 0 they keep their value, whatever `flags_in` carries. The bit order of `flags_in` is [3]=N (negative), [2]=Z (zero), [1]=V (overflow), [0]=C (carry).
- R3: Selector 0 never branches. Selector 8 always branches, whatever the flags.
- R4: Selectors 1, 2, 3 and 4 branch when Z, N, V and C are set, respectively.
- R5: Selector 5 (signed less-than) branches on N xor V. Selector 6 (signed less-or-equal) branches on Z or (N xor V). Selector 7 (unsigned lower-or-same) branches on C or Z.
- R6: For every code k from 8 to 15, `taken` is the inverse of the result of code k-8 for the same flags. So 9 is not-equal, 13 is signed greater-or-equal, 14 is signed greater-than and 15 is unsigned higher (C and Z both clear).
- R7: `taken` depends only on the stored flags and `cond_sel`, and it is combinational: it follows a selector change within the same cycle.
- R8: When taken, `next_pc` = `pc_in` + sign-extended `disp` shifted left by WORD_SHIFT (default 1), taken modulo 2^ADDR_W.
- R9: When not taken, `next_pc` equals `pc_in`, whatever the displacement.
- R10: The displacement extremes -128 and +127 are applied correctly. A target that crosses address zero in either direction wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flags_in | input | 4 | ALU flags {N,Z,V,C} |
| flags_we | input | 1 | Capture `flags_in` at the next edge |
| cond_sel | input | 4 | Branch condition selector |
| disp | input | DISP_W (8) | Signed word displacement |
| pc_in | input | ADDR_W (16) | Already-incremented program counter |
| taken | output | 1 | Branch decision |
| next_pc | output | ADDR_W (16) | Branch target or `pc_in` |

## Verification
On every cycle the assertions check several relations: that the flag register holds or loads according to the write enable, that the never and always codes give their fixed decision, that the equality code follows Z, and that `next_pc` relates to `pc_in` by the scaled displacement or by identity. Only the bench's scenarios can show the full selector table against chosen flag patterns, including the signed tests in which N and V cancel. The same applies to the reset state seen through the decision output and to the displacement extremes that wrap across address zero.

// File: rtl/cc_pkg.sv
package cc_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cc_flags_t;

   typedef enum logic [3:0] {
      CND_NEVER  = 4'd0,
      CND_EQ     = 4'd1,
      CND_MI     = 4'd2,
      CND_VS     = 4'd3,
      CND_CS     = 4'd4,
      CND_LT     = 4'd5,
      CND_LE     = 4'd6,
      CND_LS     = 4'd7,
      CND_ALWAYS = 4'd8,
      CND_NE     = 4'd9,
      CND_PL     = 4'd10,
      CND_VC     = 4'd11,
      CND_CC     = 4'd12,
      CND_GE     = 4'd13,
      CND_GT     = 4'd14,
      CND_HI     = 4'd15
   } cond_e;

endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
   import cc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      we,
   input  cc_flags_t d,
   output cc_flags_t q
);

   cc_flags_t state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= '0;
      else if (we)
         state_q <= d;
   end

   assign q = state_q;

   // R2
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(state_q));

   // R2
   flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> state_q == $past(d));

endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
   import cc_pkg::*;
#(
   parameter int FOLD_INVERSE = 1
)(
   input  cc_flags_t   flags,
   input  logic [3:0]  sel,
   output logic        taken
);

   logic signed_lt;
   assign signed_lt = flags.n ^ flags.v;

   generate
      if (FOLD_INVERSE != 0) begin : g_fold
         logic base;
         always_comb begin
            unique case (sel[2:0])
               3'd0:    base = 1'b0;
               3'd1:    base = flags.z;
               3'd2:    base = flags.n;
               3'd3:    base = flags.v;
               3'd4:    base = flags.c;
               3'd5:    base = signed_lt;
               3'd6:    base = flags.z | signed_lt;
               default: base = flags.c | flags.z;
            endcase
         end
         assign taken = base ^ sel[3];
      end else begin : g_flat
         always_comb begin
            unique case (cond_e'(sel))
               CND_NEVER:  taken = 1'b0;
               CND_EQ:     taken = flags.z;
               CND_MI:     taken = flags.n;
               CND_VS:     taken = flags.v;
               CND_CS:     taken = flags.c;
               CND_LT:     taken = signed_lt;
               CND_LE:     taken = flags.z | signed_lt;
               CND_LS:     taken = flags.c | flags.z;
               CND_ALWAYS: taken = 1'b1;
               CND_NE:     taken = ~flags.z;
               CND_PL:     taken = ~flags.n;
               CND_VC:     taken = ~flags.v;
               CND_CC:     taken = ~flags.c;
               CND_GE:     taken = ~signed_lt;
               CND_GT:     taken = ~(flags.z | signed_lt);
               default:    taken = ~(flags.c | flags.z);
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/cc_target_adder.sv
module cc_target_adder #(
   parameter int ADDR_W     = 16,
   parameter int DISP_W     = 8,
   parameter int WORD_SHIFT = 1
)(
   input  logic [ADDR_W-1:0] base_pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] target
);

   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] offset;

   assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

   generate
      if (WORD_SHIFT == 0) begin : g_byte
         assign offset = disp_ext;
      end else begin : g_word
         assign offset = {disp_ext[ADDR_W-1-WORD_SHIFT:0], {WORD_SHIFT{1'b0}}};
      end
   endgenerate

   assign target = base_pc + offset;

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
   import cc_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DISP_W       = 8,
   parameter int WORD_SHIFT   = 1,
   parameter int FOLD_INVERSE = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        flags_in,
   input  logic              flags_we,
   input  logic [3:0]        cond_sel,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] pc_in,
   output logic              taken,
   output logic [ADDR_W-1:0] next_pc
);

   initial begin
      param_disp_chk: assert (DISP_W >= 2 && DISP_W < ADDR_W)
         else $error("DISP_W must lie between 2 and ADDR_W-1");
      param_shift_chk: assert (WORD_SHIFT >= 0 && WORD_SHIFT < ADDR_W - DISP_W)
         else $error("WORD_SHIFT too large for ADDR_W");
   end

   cc_flags_t         flags_q;
   logic              take_w;
   logic [ADDR_W-1:0] target_w;

   cc_flag_reg u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (flags_we),
      .d    (cc_flags_t'(flags_in)),
      .q    (flags_q)
   );

   cc_cond_eval #(.FOLD_INVERSE(FOLD_INVERSE)) u_eval (
      .flags(flags_q),
      .sel  (cond_sel),
      .taken(take_w)
   );

   cc_target_adder #(
      .ADDR_W    (ADDR_W),
      .DISP_W    (DISP_W),
      .WORD_SHIFT(WORD_SHIFT)
   ) u_add (
      .base_pc(pc_in),
      .disp   (disp),
      .target (target_w)
   );

   assign taken   = take_w;
   assign next_pc = take_w ? target_w : pc_in;

   // R3
   never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond_sel == 4'd0 |-> !taken);

   // R3
   always_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond_sel == 4'd8 |-> taken);

   // R4
   eq_follows_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond_sel == 4'd1 |-> taken == flags_q.z);

   // R9
   fallthrough_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> next_pc == pc_in);

   // R8
   taken_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> (next_pc - pc_in) == (ADDR_W'($signed(disp)) << WORD_SHIFT));

endmodule

// File: tb/test_branch_cond_unit.sv
module test_branch_cond_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  flags_in = '0;
   logic        flags_we = 1'b0;
   logic [3:0]  cond_sel = '0;
   logic [7:0]  disp = '0;
   logic [15:0] pc_in = '0;
   logic        taken;
   logic [15:0] next_pc;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   branch_cond_unit i_branch_cond_unit (
      .clk(clk), .rst_n(rst_n), .flags_in(flags_in), .flags_we(flags_we),
      .cond_sel(cond_sel), .disp(disp), .pc_in(pc_in),
      .taken(taken), .next_pc(next_pc)
   );

   // {flags N Z V C, selector, expected taken}
   localparam logic [8:0] VEC [24] = '{
      {4'b0000, 4'd0,  1'b0}, {4'b0000, 4'd8,  1'b1},
      {4'b0100, 4'd1,  1'b1}, {4'b0000, 4'd1,  1'b0},
      {4'b0100, 4'd9,  1'b0}, {4'b1000, 4'd2,  1'b1},
      {4'b1000, 4'd10, 1'b0}, {4'b0010, 4'd3,  1'b1},
      {4'b0010, 4'd11, 1'b0}, {4'b0001, 4'd4,  1'b1},
      {4'b0001, 4'd12, 1'b0}, {4'b1000, 4'd5,  1'b1},
      {4'b1010, 4'd5,  1'b0}, {4'b0010, 4'd5,  1'b1},
      {4'b1010, 4'd13, 1'b1}, {4'b0100, 4'd6,  1'b1},
      {4'b0000, 4'd6,  1'b0}, {4'b0000, 4'd14, 1'b1},
      {4'b0001, 4'd7,  1'b1}, {4'b0000, 4'd7,  1'b0},
      {4'b0100, 4'd15, 1'b0}, {4'b0000, 4'd15, 1'b1},
      {4'b1111, 4'd0,  1'b0}, {4'b1111, 4'd8,  1'b1}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_flags(input logic [3:0] f);
      @(negedge clk);
      flags_in = f;
      flags_we = 1'b1;
      @(negedge clk);
      flags_we = 1'b0;
   endtask

   task automatic probe(input logic [3:0] s, input logic [7:0] d, input logic [15:0] pc);
      cond_sel = s;
      disp     = d;
      pc_in    = pc;
      #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1: flags are clear during and right after reset
      @(negedge clk);
      probe(4'd1, 8'h00, 16'h0100);
      chk("R1 eq in reset", {15'd0, taken}, 16'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      probe(4'd1, 8'h00, 16'h0100);
      chk("R1 eq after reset", {15'd0, taken}, 16'd0);
      probe(4'd9, 8'h00, 16'h0100);
      chk("R1 ne after reset", {15'd0, taken}, 16'd1);
      probe(4'd14, 8'h00, 16'h0100);
      chk("R1 gt after reset", {15'd0, taken}, 16'd1);

      // R3 R4 R5 R6 R8 R9: selector table
      for (int i = 0; i < 24; i++) begin
         load_flags(VEC[i][8:5]);
         probe(VEC[i][4:1], 8'h05, 16'h1000);
         chk($sformatf("R3-R6 vec %0d taken", i), {15'd0, taken}, {15'd0, VEC[i][0]});
         chk($sformatf("R8 R9 vec %0d pc", i), next_pc, VEC[i][0] ? 16'h100A : 16'h1000);
      end

      // R2: disabled write leaves flags unchanged
      load_flags(4'b0100);
      @(negedge clk);
      flags_in = 4'b1011;
      repeat (2) @(negedge clk);
      probe(4'd1, 8'h00, 16'h0200);
      chk("R2 hold Z", {15'd0, taken}, 16'd1);
      probe(4'd4, 8'h00, 16'h0200);
      chk("R2 hold C", {15'd0, taken}, 16'd0);

      // R7: decision follows selector within the cycle
      probe(4'd9, 8'h00, 16'h0200);
      chk("R7 same-cycle select", {15'd0, taken}, 16'd0);

      // R10: displacement extremes and wrap
      probe(4'd8, 8'h80, 16'h1000);
      chk("R10 disp -128", next_pc, 16'h0F00);
      probe(4'd8, 8'h7F, 16'h1000);
      chk("R10 disp +127", next_pc, 16'h10FE);
      probe(4'd8, 8'hFE, 16'h0002);
      chk("R10 wrap below zero", next_pc, 16'hFFFE);
      probe(4'd8, 8'h01, 16'hFFFE);
      chk("R10 wrap above top", next_pc, 16'h0000);
      probe(4'd0, 8'h7F, 16'h1234);
      chk("R9 never ignores disp", next_pc, 16'h1234);

      finish_run();
   end

endmodule